// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits between a local bus and a PCI master. Three programmable windows each claim a slice of the 32-bit local address space and redirect it to a PCI address with a PCI cycle type. Windows 0 and 1 are general memory windows whose size can be set anywhere from 1 MB to 2 GB. Window 2 is a fixed 16 MB I/O window.

Each window is set up through a shared register write port, using a base register and a map register. The base register holds the compare address, a size code and an enable. The map register holds the replacement high address bits, a cycle-type code and a low-bit pass flag. The windows are searched in a fixed order from index 0 upward, and the first enabled window that contains the address is used. Software can therefore enlarge window 0 so that it covers window 1, reprogram window 1 for another use such as configuration cycles, and later shrink window 0 again.

Each lookup gives a registered result one cycle later. The result is a hit or miss flag, the index of the winning window, the translated PCI address and the 3-bit cycle type.

Top module: `lbus_win_xlate`

## Requirements
- R1: After reset, every window is disabled. All outputs are zero, and any lookup misses.
- R2: When `lk_valid` is high at a clock edge, the result is on the outputs after that edge and `out_valid` is high for exactly that one cycle. When no lookup is made, `out_valid` is low and `out_hit`, `out_miss`, `out_win`, `out_kind` and `out_addr` are all zero.
- R3: Window 0 or 1 covers 2^(20+s) bytes, where s is the size code in base bits 7:4. The window matches when local address bits 31:(20+s) equal base bits 31:(20+s). Size codes above 11 act as 11, which gives 2 GB.
- R4: A memory-window hit replaces local address bits 31:(20+s) with the matching bits of map bits 15:4, which stand for PCI bits 31:20. All address bits below the window size pass through unchanged.
- R5: When map bit 0 is clear, a memory-window hit forces PCI address bits 1:0 to zero. When map bit 0 is set, those two bits pass through from the local address.
- R6: A memory-window hit reports map bits 3:1 as the cycle type (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple). A hit in window 2 always reports 001.
- R7: Window 2 matches when local address bits 31:24 equal its base bits 15:8. A hit takes PCI bits 31:24 from map bits 15:8 and passes local bits 23:0 through unchanged.
- R8: When several enabled windows contain the address, the lowest index wins. `out_win` reports the index of the winning window.
- R9: A window whose base bit 0 (enable) is clear never matches.
- R10: On a miss, `out_miss` is 1 and `out_hit` is 0. `out_addr`, `out_kind` and `out_win` are all zero.
- R11: A register write takes effect from the next clock edge. A lookup made in the same cycle as a write still uses the old settings.
- R12: `cfg_sel` chooses the register to write: 0 base 0, 1 map 0, 2 base 1, 3 map 1, 4 base 2, 5 map 2. Writes with select values 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (see R12) |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_hit | output | 1 | A window matched |
| out_miss | output | 1 | The lookup matched no window |
| out_win | output | 2 | Index of the winning window |
| out_kind | output | 3 | PCI cycle type |
| out_addr | output | 32 | Translated PCI address |

## Verification
A register write goes in on one clock edge and affects only lookups captured on a later edge. A lookup result appears exactly one edge after the request. The bench drives inputs on the falling edge and samples the outputs on the following falling edge, so every result is read in the cycle it is due. One directed test issues a lookup and a write in the same cycle and checks that the old settings are used. The bench also checks that the outputs return to zero in the cycle after each result.

// File: rtl/win_xlate_pkg.sv
// Shared widths, cycle-type codes and record types for the window translator.
// Assumes a 32-bit local and PCI address space with 1 MB memory granules.
package win_xlate_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_LSB   = 20;
    localparam int IO_LSB     = 24;
    localparam int NUM_MEM    = 2;
    localparam int NUM_WIN    = NUM_MEM + 1;
    localparam int MAX_CODE   = 11;
    localparam int HI_W       = ADDR_W - PAGE_LSB;
    localparam int IO_HI_W    = ADDR_W - IO_LSB;
    localparam int MAP_W      = 16;
    localparam int CODE_W     = 4;
    localparam int KIND_W     = 3;
    localparam int WIN_IDX_W  = $clog2(NUM_WIN);
    localparam int SEL_W      = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_IACK    = 3'b000,
        KIND_IO      = 3'b001,
        KIND_MEM     = 3'b011,
        KIND_CONFIG  = 3'b101,
        KIND_MEMMULT = 3'b110
    } cyc_kind_e;

    typedef struct packed {
        logic [HI_W-1:0]   base_hi;
        logic [CODE_W-1:0] size_code;
        logic              en;
        logic [MAP_W-1:0]  map;
    } mem_win_cfg_t;

    typedef struct packed {
        logic [IO_HI_W-1:0] base_hi;
        logic               en;
        logic [IO_HI_W-1:0] map_hi;
    } io_win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
    } win_res_t;
endpackage

// File: rtl/win_cfg_regs.sv
// Base/map register store for all windows.
// Assumes the select values in the brief; unknown selects are ignored.
// Writes land on the clock edge that samples cfg_we.
module win_cfg_regs
    import win_xlate_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SEL_W-1:0]            sel,
    input  logic [ADDR_W-1:0]           wdata,
    output mem_win_cfg_t [NUM_MEM-1:0]  mem_cfg,
    output io_win_cfg_t                 io_cfg
);
    localparam logic [SEL_W-1:0] IO_BASE_SEL = SEL_W'(2 * NUM_MEM);
    localparam logic [SEL_W-1:0] IO_MAP_SEL  = SEL_W'(2 * NUM_MEM + 1);

    logic unused_wdata;
    assign unused_wdata = ^wdata[PAGE_LSB-1:MAP_W];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MEM; gi++) begin : g_mem
            localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(2 * gi);
            localparam logic [SEL_W-1:0] MAP_SEL  = SEL_W'(2 * gi + 1);
            // Hold base and map fields of one memory window.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_cfg[gi] <= '0;
                end else if (we && sel == BASE_SEL) begin
                    mem_cfg[gi].base_hi   <= wdata[ADDR_W-1:PAGE_LSB];
                    mem_cfg[gi].size_code <= wdata[7:4];
                    mem_cfg[gi].en        <= wdata[0];
                end else if (we && sel == MAP_SEL) begin
                    mem_cfg[gi].map <= wdata[MAP_W-1:0];
                end
            end
        end
    endgenerate

    // Hold the I/O window base and map fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_cfg <= '0;
        end else if (we && sel == IO_BASE_SEL) begin
            io_cfg.base_hi <= wdata[MAP_W-1:MAP_W-IO_HI_W];
            io_cfg.en      <= wdata[0];
        end else if (we && sel == IO_MAP_SEL) begin
            io_cfg.map_hi <= wdata[MAP_W-1:MAP_W-IO_HI_W];
        end
    end
endmodule

// File: rtl/win_mem_match.sv
// Range compare and translation for one variable-size memory window.
// Assumes size codes above MAX_CODE saturate; purely combinational.
module win_mem_match
    import win_xlate_pkg::*;
(
    input  mem_win_cfg_t       cfg,
    input  logic [ADDR_W-1:0]  addr,
    output win_res_t           res
);
    logic [CODE_W-1:0] eff_code;
    logic [HI_W-1:0]   keep_mask;
    logic [HI_W-1:0]   addr_hi;
    logic [HI_W-1:0]   map_hi;
    logic              in_range;

    // Saturate the size code and build the compared-bit mask.
    always_comb begin
        eff_code  = (cfg.size_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : cfg.size_code;
        keep_mask = {HI_W{1'b1}} << eff_code;
        addr_hi   = addr[ADDR_W-1:PAGE_LSB];
        map_hi    = cfg.map[MAP_W-1:MAP_W-HI_W];
        in_range  = cfg.en && (((addr_hi ^ cfg.base_hi) & keep_mask) == '0);
    end

    // Form the translated address and cycle type for a hit.
    always_comb begin
        res = '0;
        if (in_range) begin
            res.hit = 1'b1;
            res.kind = cfg.map[3:1];
            res.addr[ADDR_W-1:PAGE_LSB] = (map_hi & keep_mask) | (addr_hi & ~keep_mask);
            res.addr[PAGE_LSB-1:2] = addr[PAGE_LSB-1:2];
            res.addr[1:0] = cfg.map[0] ? addr[1:0] : 2'b00;
        end
    end
endmodule

// File: rtl/win_io_match.sv
// Range compare and translation for the fixed 16 MB I/O window.
// Assumes low address bits always pass through; purely combinational.
module win_io_match
    import win_xlate_pkg::*;
(
    input  io_win_cfg_t        cfg,
    input  logic [ADDR_W-1:0]  addr,
    output win_res_t           res
);
    // Compare the top byte and swap in the mapped top byte.
    always_comb begin
        res = '0;
        if (cfg.en && addr[ADDR_W-1:IO_LSB] == cfg.base_hi) begin
            res.hit  = 1'b1;
            res.kind = KIND_IO;
            res.addr = {cfg.map_hi, addr[IO_LSB-1:0]};
        end
    end
endmodule

// File: rtl/win_prio_sel.sv
// Picks the lowest-index hitting window and registers the result.
// Assumes res[i] is all-zero when window i misses.
module win_prio_sel
    import win_xlate_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid,
    input  win_res_t [NUM_WIN-1:0]      res,
    output logic                        out_valid,
    output logic                        out_hit,
    output logic                        out_miss,
    output logic [WIN_IDX_W-1:0]        out_win,
    output logic [KIND_W-1:0]           out_kind,
    output logic [ADDR_W-1:0]           out_addr
);
    win_res_t             pick;
    logic [WIN_IDX_W-1:0] pick_idx;

    // Scan from the top so the lowest hitting index is kept last.
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (res[i].hit) begin
                pick     = res[i];
                pick_idx = WIN_IDX_W'(i);
            end
        end
    end

    // Register the chosen result; zero outputs when idle or missing.
    always_ff @(posedge clk) begin
        if (!rst_n || !valid) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_win   <= '0;
            out_kind  <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= 1'b1;
            out_hit   <= pick.hit;
            out_miss  <= !pick.hit;
            out_win   <= pick_idx;
            out_kind  <= pick.kind;
            out_addr  <= pick.addr;
        end
    end
endmodule

// File: rtl/lbus_win_xlate.sv
// Top level: three-window local-to-PCI address translator.
// Assumes one lookup per cycle at most; result latency is one clock.
module lbus_win_xlate
    import win_xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic                  lk_valid,
    input  logic [31:0]           lk_addr,
    output logic                  out_valid,
    output logic                  out_hit,
    output logic                  out_miss,
    output logic [1:0]            out_win,
    output logic [2:0]            out_kind,
    output logic [31:0]           out_addr
);
    mem_win_cfg_t [NUM_MEM-1:0] mem_cfg;
    io_win_cfg_t                io_cfg;
    win_res_t [NUM_WIN-1:0]     res;

    win_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .mem_cfg (mem_cfg),
        .io_cfg  (io_cfg)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MEM; gi++) begin : g_match
            win_mem_match u_mem (
                .cfg  (mem_cfg[gi]),
                .addr (lk_addr),
                .res  (res[gi])
            );
        end
    endgenerate

    win_io_match u_io (
        .cfg  (io_cfg),
        .addr (lk_addr),
        .res  (res[NUM_WIN-1])
    );

    win_prio_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (lk_valid),
        .res       (res),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_miss  (out_miss),
        .out_win   (out_win),
        .out_kind  (out_kind),
        .out_addr  (out_addr)
    );
endmodule

// File: rtl/win_xlate_chk.sv
// Port-level temporal checks for the window translator, bound to the top.
module win_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        out_valid,
    input logic        out_hit,
    input logic        out_miss,
    input logic [1:0]  out_win,
    input logic [2:0]  out_kind,
    input logic [31:0] out_addr
);
    // A request yields a result on the next cycle.
    p_req_to_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);

    // No request means no result next cycle.
    p_no_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !out_valid);

    // Idle outputs stay zero.
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_miss && out_addr == 32'd0 && out_kind == 3'd0));

    // A miss carries zero payload and excludes a hit.
    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (!out_hit && out_addr == 32'd0 && out_kind == 3'd0 && out_win == 2'd0));

    // A valid result is either a hit or a miss.
    p_hit_or_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_miss));

    // The I/O window always reports the I/O cycle type.
    p_io_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit && out_win == 2'd2) |-> out_kind == 3'b001);

    // The I/O window keeps the low 24 address bits.
    p_io_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit && out_win == 2'd2) |-> out_addr[23:0] == $past(lk_addr[23:0]));

    // Low two bits are either forced to zero or copied.
    p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_addr[1:0] == 2'b00 || out_addr[1:0] == $past(lk_addr[1:0])));

    // Winning index names an existing window.
    p_win_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_win < 2'd3);
endmodule

bind lbus_win_xlate win_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_miss  (out_miss),
    .out_win   (out_win),
    .out_kind  (out_kind),
    .out_addr  (out_addr)
);

// File: tb/lbus_win_xlate_tb.sv
`timescale 1ns/1ps
module lbus_win_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [1:0]  out_win;
    logic [2:0]  out_kind;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lbus_win_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
        .out_win(out_win), .out_kind(out_kind), .out_addr(out_addr)
    );

    // Vector: {local addr, hit, win, kind, PCI addr}
    localparam int NVEC = 8;
    localparam logic [69:0] VEC [NVEC] = '{
        {32'h4123_4567, 1'b1, 2'd0, 3'd3, 32'h0123_4564},
        {32'h5ABC_DEF3, 1'b1, 2'd1, 3'd6, 32'h1ABC_DEF3},
        {32'h6012_3456, 1'b1, 2'd2, 3'd1, 32'hAB12_3456},
        {32'h7000_0000, 1'b0, 2'd0, 3'd0, 32'h0000_0000},
        {32'h4FFF_FFFF, 1'b1, 2'd0, 3'd3, 32'h0FFF_FFFC},
        {32'h3FFF_FFFF, 1'b0, 2'd0, 3'd0, 32'h0000_0000},
        {32'h6100_0000, 1'b0, 2'd0, 3'd0, 32'h0000_0000},
        {32'h5000_0002, 1'b1, 2'd1, 3'd6, 32'h1000_0002}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one lookup and return the outputs one edge later.
    task automatic look(input logic [31:0] a, input string req,
                        input logic hit, input logic [1:0] win,
                        input logic [2:0] kind, input logic [31:0] pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " hit/miss"}, 64'({out_hit, out_miss}), 64'({hit, !hit}));
        check({req, " win/kind"}, 64'({out_win, out_kind}), 64'({win, kind}));
        check({req, " addr"}, 64'(out_addr), 64'(pa));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and a miss on an unprogrammed block
        check("R1 reset outputs", 64'({out_valid, out_hit, out_miss, out_win, out_kind, out_addr}), 64'd0);
        look(32'h4123_4567, "R1 lookup after reset", 1'b0, 2'd0, 3'd0, 32'd0);

        // Program the normal layout (R12 select codes)
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_0006);
        wr(3'd2, 32'h5000_0081);
        wr(3'd3, 32'h0000_100D);
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_AB00);

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            look(VEC[i][69:38], "R4 table", VEC[i][37], VEC[i][36:35], VEC[i][34:32], VEC[i][31:0]);
            @(negedge clk);
            check("R2 idle after result", 64'({out_valid, out_hit, out_miss, out_addr}), 64'd0);
        end

        // R12: select codes 6 and 7 change nothing
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        look(32'h6012_3456, "R12 ignored sel", 1'b1, 2'd2, 3'd1, 32'hAB12_3456);
        look(32'h4123_4567, "R12 ignored sel", 1'b1, 2'd0, 3'd3, 32'h0123_4564);

        // R8: enlarge window 0 to 512 MB, hiding window 1
        wr(3'd0, 32'h4000_0091);
        look(32'h5ABC_DEF3, "R8 priority", 1'b1, 2'd0, 3'd3, 32'h1ABC_DEF0);

        // R9: disable window 0
        wr(3'd0, 32'h4000_0090);
        look(32'h4123_4567, "R9 disabled", 1'b0, 2'd0, 3'd0, 32'd0);
        look(32'h5ABC_DEF3, "R9 fall through", 1'b1, 2'd1, 3'd6, 32'h1ABC_DEF3);

        // R3: 1 MB window with full high-bit replacement
        wr(3'd0, 32'h4010_0001);
        wr(3'd1, 32'h0000_1237);
        look(32'h4018_9ABC, "R3 1MB hit", 1'b1, 2'd0, 3'd3, 32'h1238_9ABC);
        look(32'h4020_0000, "R3 1MB edge", 1'b0, 2'd0, 3'd0, 32'd0);

        // R3: size code 15 saturates to 2 GB
        wr(3'd0, 32'h8000_00F1);
        look(32'hC000_0001, "R3 saturate", 1'b1, 2'd0, 3'd3, 32'h4000_0001);
        look(32'h3000_0000, "R3 saturate miss", 1'b0, 2'd0, 3'd0, 32'd0);

        // R11: lookup in the same cycle as a disabling write uses old settings
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0000_6000;
        lk_valid = 1'b1; lk_addr = 32'h6012_3456;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        check("R11 old settings", 64'({out_hit, out_win, out_addr}), 64'({1'b1, 2'd2, 32'hAB12_3456}));
        look(32'h6012_3456, "R11 new settings", 1'b0, 2'd0, 3'd0, 32'd0);

        finished = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule